// File: doc/BRIEF.md
# Converter Host Read Controller

This block is the host side of a link to a 16-bit successive-approximation converter that uses a conversion strobe, a shift clock, a serial data input and a serial data output. Each read starts on a trigger pulse or on a periodic tick. The block raises the strobe and holds it for a programmed number of system clocks, which covers the conversion time. It then drops the strobe and waits a setup interval. After that it produces sixteen shift-clock pulses from a programmable divider. During those pulses it sends a two-bit multiplexer word to the converter and collects the sixteen result bits. A final hold interval follows, and then the result is offered on a valid/ready output.

The multiplexer word sent during a read sets up the conversion that the next read will fetch. For this reason the block tags each result with the word sent in the previous read. The first result after reset is marked as having no known channel. The shift-clock half period, the strobe-high time and the sample period are all runtime inputs. A new read waits until the last result has been taken.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, the strobe, the shift clock, the data line to the converter and the result-valid flag are all low.
- R2: A trigger sampled high on a clock edge while the block is idle raises the strobe at that same edge. The strobe then stays high for exactly cfg_wait+1 clocks.
- R3: The first shift-clock rising edge comes exactly cfg_div+1 clocks after the strobe falls.
- R4: Each read issues exactly 16 shift-clock pulses, and the strobe stays low throughout. Every high phase lasts cfg_div+1 clocks, and so does every low phase between pulses.
- R5: The converter data line is sampled at each shift-clock rising edge, and the first bit sampled is the most significant. The 16 samples make up res_data.
- R6: The line to the converter carries ch_sel[1] (1 = single-ended) during the first shift-clock pulse and ch_sel[0] (odd/sign) during the second, then 0. ch_sel is captured when the read starts, and the line does not change while the shift clock is high.
- R7: res_chan carries the ch_sel value captured by the previous read. res_nochan is 1 on the first result after reset and 0 on every later result.
- R8: res_valid rises exactly cfg_div+1 clocks after the last shift-clock falling edge. It stays high, with res_data unchanged, until res_ready is seen high. It then drops on the next clock.
- R9: No read starts while a result is waiting. A trigger that arrives during that time is held. The held read raises the strobe on the second clock edge after the accepting edge.
- R10: When cfg_period is nonzero, reads start every cfg_period clocks, provided each read finishes and is accepted within the period. When cfg_period is 0, no periodic reads start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 8 | Shift-clock half period minus one, in clocks |
| cfg_wait | input | 12 | Strobe-high time minus one, in clocks |
| cfg_period | input | 16 | Sample period in clocks; 0 disables the periodic start |
| trig | input | 1 | Single-cycle read request |
| ch_sel | input | 2 | Multiplexer word for the next conversion: {single-ended, odd/sign} |
| adc_conv | output | 1 | Conversion strobe |
| adc_sck | output | 1 | Shift clock |
| adc_sdi | output | 1 | Serial data to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Unsigned conversion result |
| res_chan | output | 2 | Multiplexer word that applied to this result |
| res_nochan | output | 1 | res_chan has no meaning (first result after reset) |

## Verification
Every latency is counted in clocks from the triggering event. The strobe rises on the edge that samples the trigger. It falls cfg_wait+1 clocks later. The first shift-clock rise follows cfg_div+1 clocks after that, and each phase lasts cfg_div+1 clocks. Valid rises cfg_div+1 clocks after the last fall, and a held read starts on the second edge after acceptance. The bench samples on falling system-clock edges and timestamps every change of strobe, shift clock and valid. It compares each interval with the value computed from the cfg_div, cfg_wait and cfg_period it applied. It repeats this over a sweep of divider and wait settings. It reads results one sample after valid rises, so no check depends on event order at an edge.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  // Read sequencer states; order is not decoded outside the sequencer.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_SETUP,
    ST_SCKH,
    ST_SCKL,
    ST_HOLD,
    ST_OUT
  } rd_state_e;

endpackage

// File: rtl/adc_rd_req.sv
// Request source: periodic tick timer plus a sticky pending flag.
module adc_rd_req #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] cfg_period,
  input  logic             trig,
  input  logic             start,
  output logic             req
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             per_en;
  logic             tick;

  always_comb begin
    per_en = (cfg_period != '0);
    tick   = per_en && (cnt_q >= (cfg_period - PER_W'(1)));
    if (!per_en || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + PER_W'(1);
    end
    req    = pend_q | trig | tick;
    pend_d = start ? 1'b0 : (pend_q | trig | tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  // R9
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !start) |=> req);

  // R10
  period_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_period == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/adc_rd_seq.sv
// Read sequencer: strobe timing, shift-clock phases, bit count, output hold.
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int WAIT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req,
  input  logic              res_ready,
  output logic              start,
  output logic              rise,
  output logic              fall,
  output logic              conv,
  output logic              sck,
  output logic              valid
);

  localparam int CNT_W = (DIV_W > WAIT_W) ? DIV_W : WAIT_W;
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W);

  rd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             conv_q, sck_q;
  logic             phase_end;

  always_comb begin
    phase_end = (cnt_q == '0);
    state_d   = state_q;
    cnt_d     = phase_end ? cnt_q : (cnt_q - CNT_W'(1));
    bit_d     = bit_q;
    start     = 1'b0;
    rise      = 1'b0;
    fall      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        bit_d = '0;
        if (req) begin
          start   = 1'b1;
          state_d = ST_CONV;
          cnt_d   = CNT_W'(cfg_wait);
        end
      end
      ST_CONV: begin
        if (phase_end) begin
          state_d = ST_SETUP;
          cnt_d   = CNT_W'(cfg_div);
        end
      end
      ST_SETUP, ST_SCKL: begin
        if (phase_end) begin
          state_d = ST_SCKH;
          cnt_d   = CNT_W'(cfg_div);
          rise    = 1'b1;
          bit_d   = bit_q + BIT_W'(1);
        end
      end
      ST_SCKH: begin
        if (phase_end) begin
          fall    = 1'b1;
          cnt_d   = CNT_W'(cfg_div);
          state_d = (bit_q == LAST_BIT) ? ST_HOLD : ST_SCKL;
        end
      end
      ST_HOLD: begin
        if (phase_end) begin
          state_d = ST_OUT;
        end
      end
      ST_OUT: begin
        if (res_ready) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      conv_q  <= 1'b0;
      sck_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      conv_q  <= (state_d == ST_CONV);
      sck_q   <= (state_d == ST_SCKH);
    end
  end

  assign conv  = conv_q;
  assign sck   = sck_q;
  assign valid = (state_q == ST_OUT);

  // R4
  sck_conv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_q && sck_q));

  // R4
  bit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= LAST_BIT);

  // R2
  conv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_q) |-> $past(req));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !res_ready) |=> valid);

  // R9
  no_conv_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !conv_q);

endmodule

// File: rtl/adc_rd_shift.sv
// Serial datapath: multiplexer word out, result bits in, channel tag.
module adc_rd_shift #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  ch_sel,
  input  logic              start,
  input  logic              rise,
  input  logic              fall,
  input  logic              sck,
  input  logic              sdo,
  output logic              sdi,
  output logic [DATA_W-1:0] data,
  output logic [SEL_W-1:0]  chan,
  output logic              nochan
);

  logic [SEL_W-1:0]  tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [SEL_W-1:0]  cur_q, cur_d;
  logic [SEL_W-1:0]  tag_q, tag_d;
  logic              have_q, have_d;
  logic              tag_ok_q, tag_ok_d;

  always_comb begin
    tx_d     = tx_q;
    rx_d     = rx_q;
    cur_d    = cur_q;
    tag_d    = tag_q;
    have_d   = have_q;
    tag_ok_d = tag_ok_q;
    if (start) begin
      tx_d     = ch_sel;
      cur_d    = ch_sel;
      tag_d    = cur_q;
      tag_ok_d = have_q;
      have_d   = 1'b1;
    end else if (fall) begin
      tx_d = tx_q << 1;
    end
    if (rise) begin
      rx_d = {rx_q[DATA_W-2:0], sdo};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      rx_q     <= '0;
      cur_q    <= '0;
      tag_q    <= '0;
      have_q   <= 1'b0;
      tag_ok_q <= 1'b0;
    end else begin
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      cur_q    <= cur_d;
      tag_q    <= tag_d;
      have_q   <= have_d;
      tag_ok_q <= tag_ok_d;
    end
  end

  assign sdi    = tx_q[SEL_W-1];
  assign data   = rx_q;
  assign chan   = tag_q;
  assign nochan = !tag_ok_q;

  // R6
  sdi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(sdi));

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(rx_q));

  // R7
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(tag_q) && $stable(tag_ok_q)));

endmodule

// File: rtl/adc_rd_ctrl.sv
// Top: host-side read controller for a strobe-and-clock serial converter.
module adc_rd_ctrl #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2,
  parameter int DIV_W  = 8,
  parameter int WAIT_W = 12,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic              trig,
  input  logic [SEL_W-1:0]  ch_sel,
  output logic              adc_conv,
  output logic              adc_sck,
  output logic              adc_sdi,
  input  logic              adc_sdo,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic [SEL_W-1:0]  res_chan,
  output logic              res_nochan
);

  logic req;
  logic start;
  logic rise;
  logic fall;

  adc_rd_req #(
    .PER_W(PER_W)
  ) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_period(cfg_period),
    .trig      (trig),
    .start     (start),
    .req       (req)
  );

  adc_rd_seq #(
    .DATA_W(DATA_W),
    .DIV_W (DIV_W),
    .WAIT_W(WAIT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_div  (cfg_div),
    .cfg_wait (cfg_wait),
    .req      (req),
    .res_ready(res_ready),
    .start    (start),
    .rise     (rise),
    .fall     (fall),
    .conv     (adc_conv),
    .sck      (adc_sck),
    .valid    (res_valid)
  );

  adc_rd_shift #(
    .DATA_W(DATA_W),
    .SEL_W (SEL_W)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .ch_sel(ch_sel),
    .start (start),
    .rise  (rise),
    .fall  (fall),
    .sck   (adc_sck),
    .sdo   (adc_sdo),
    .sdi   (adc_sdi),
    .data  (res_data),
    .chan  (res_chan),
    .nochan(res_nochan)
  );

endmodule

// File: tb/sim_adc_rd_ctrl.sv
module sim_adc_rd_ctrl;

  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_div;
  logic [11:0] cfg_wait;
  logic [15:0] cfg_period;
  logic        trig;
  logic [1:0]  ch_sel;
  logic        adc_conv, adc_sck, adc_sdi, adc_sdo;
  logic        res_valid, res_ready;
  logic [15:0] res_data;
  logic [1:0]  res_chan;
  logic        res_nochan;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  adc_rd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_wait(cfg_wait),
    .cfg_period(cfg_period), .trig(trig), .ch_sel(ch_sel),
    .adc_conv(adc_conv), .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_chan(res_chan), .res_nochan(res_nochan)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Converter model and timing monitor, evaluated on falling system edges.
  logic [15:0] adc_word;
  logic [15:0] m_word, m_sh;
  logic [1:0]  sdi_bits;
  int n = 0, n_crise = 0, n_crise_prev = 0, n_cfall = 0, n_rise = 0, n_fall = 0;
  int rise_cnt = 0, bad_hi = 0, bad_lo = 0, setup = 0, hold = 0, crises = 0;
  int cur_div = 0;
  logic p_conv = 1'b0, p_sck = 1'b0, p_valid = 1'b0;

  initial begin
    m_word   = '0;
    m_sh     = '0;
    sdi_bits = '0;
    adc_sdo  = 1'b0;
  end

  always @(negedge clk) begin
    n++;
    if (adc_conv && !p_conv) begin
      m_word       = adc_word;
      n_crise_prev = n_crise;
      n_crise      = n;
      rise_cnt     = 0;
      bad_hi       = 0;
      bad_lo       = 0;
      sdi_bits     = '0;
      crises++;
    end
    if (!adc_conv && p_conv) begin
      n_cfall = n;
      m_sh    = m_word;
    end
    if (adc_sck && !p_sck) begin
      if (rise_cnt == 0) setup = n - n_cfall;
      else if (n - n_fall != cur_div + 1) bad_lo++;
      if (rise_cnt < 2) sdi_bits[1 - rise_cnt] = adc_sdi;
      rise_cnt++;
      n_rise = n;
    end
    if (!adc_sck && p_sck) begin
      if (n - n_rise != cur_div + 1) bad_hi++;
      n_fall = n;
      m_sh   = m_sh << 1;
    end
    if (res_valid && !p_valid) hold = n - n_fall;
    adc_sdo = m_sh[15];
    p_conv  = adc_conv;
    p_sck   = adc_sck;
    p_valid = res_valid;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  int  prev_sel = 0;
  bit  first    = 1;

  task automatic wait_result();
    while (!res_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_result(input logic [1:0] sel, input logic [15:0] word, input int wt);
    chk(n_cfall - n_crise == wt + 1, "R2 strobe high length", n_cfall - n_crise, wt + 1);
    chk(setup == cur_div + 1, "R3 strobe fall to first clock rise", setup, cur_div + 1);
    chk(rise_cnt == 16, "R4 clock pulse count", rise_cnt, 16);
    chk(bad_hi == 0, "R4 high phase width errors", bad_hi, 0);
    chk(bad_lo == 0, "R4 low phase width errors", bad_lo, 0);
    chk(hold == cur_div + 1, "R8 last fall to valid", hold, cur_div + 1);
    chk(res_data == word, "R5 result data", res_data, word);
    chk(sdi_bits == sel, "R6 multiplexer word sent", sdi_bits, sel);
    chk(res_nochan == first, "R7 no-channel flag", res_nochan, first);
    if (!first) chk(res_chan == 2'(prev_sel), "R7 channel tag", res_chan, prev_sel);
  endtask

  task automatic accept_result(input logic [1:0] sel);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid, "R8 valid drops after accept", res_valid, 0);
    prev_sel = sel;
    first    = 0;
  endtask

  task automatic do_read(input logic [1:0] sel, input logic [15:0] word, input int wt);
    ch_sel   = sel;
    adc_word = word;
    trig     = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(adc_conv == 1'b1, "R2 strobe up one clock after trigger", adc_conv, 1);
    wait_result();
    check_result(sel, word, wt);
    accept_result(sel);
  endtask

  initial begin
    int c0;
    int bad;
    logic [15:0] held;
    rst_n      = 1'b0;
    cfg_div    = 8'd1;
    cfg_wait   = 12'd3;
    cfg_period = '0;
    trig       = 1'b0;
    ch_sel     = '0;
    res_ready  = 1'b0;
    adc_word   = '0;
    repeat (3) @(negedge clk);
    chk({adc_conv, adc_sck, adc_sdi, res_valid} == 4'b0, "R1 outputs in reset",
        {adc_conv, adc_sck, adc_sdi, res_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({adc_conv, adc_sck, adc_sdi, res_valid} == 4'b0, "R1 outputs idle after reset",
        {adc_conv, adc_sck, adc_sdi, res_valid}, 0);

    // Sweep of divider and wait settings with several data/select patterns.
    for (int d = 0; d < 3; d++) begin
      for (int w = 0; w < 6; w += 2) begin
        cfg_div  = 8'(d);
        cfg_wait = 12'(w);
        cur_div  = d;
        for (int k = 0; k < 4; k++) begin
          logic [15:0] wd;
          int idx;
          idx = d * 12 + w * 2 + k;
          if (idx == 0)      wd = 16'hFFFF;
          else if (idx == 1) wd = 16'h0000;
          else if (idx == 2) wd = 16'h8001;
          else               wd = 16'((idx * 40503 + 12345) & 16'hFFFF);
          do_read(2'(k ^ d), wd, w);
        end
      end
    end

    // Stall: result held, trigger during stall remembered.
    cfg_div  = 8'd1;
    cfg_wait = 12'd2;
    cur_div  = 1;
    do_read(2'b10, 16'h1234, 2);
    ch_sel   = 2'b10;
    adc_word = 16'hBEEF;
    trig     = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    wait_result();
    held = res_data;
    c0   = crises;
    bad  = 0;
    ch_sel   = 2'b01;
    adc_word = 16'h4C3A;
    for (int i = 0; i < 20; i++) begin
      if (i == 5) trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      if (!res_valid || res_data != held) bad++;
    end
    chk(bad == 0, "R8 result held while not ready", bad, 0);
    chk(crises == c0, "R9 no strobe while result waits", crises - c0, 0);
    check_result(2'b10, 16'hBEEF, 2);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    prev_sel  = 2;
    first     = 0;
    chk(adc_conv == 1'b0, "R9 strobe low one clock after accept", adc_conv, 0);
    @(negedge clk);
    chk(adc_conv == 1'b1, "R9 held read starts second edge after accept", adc_conv, 1);
    wait_result();
    check_result(2'b01, 16'h4C3A, 2);
    accept_result(2'b01);

    // Periodic starts.
    cfg_wait   = 12'd3;
    adc_word   = 16'h0F0F;
    ch_sel     = 2'b11;
    res_ready  = 1'b1;
    cfg_period = 16'd150;
    c0 = crises;
    while (crises < c0 + 2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      c0 = crises;
      while (crises == c0) @(negedge clk);
      chk(n_crise - n_crise_prev == 150, "R10 periodic start interval",
          n_crise - n_crise_prev, 150);
    end
    cfg_period = '0;
    repeat (200) @(negedge clk);
    c0 = crises;
    repeat (400) @(negedge clk);
    chk(crises == c0, "R10 period zero disables starts", crises - c0, 0);
    res_ready = 1'b0;

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule